// File: doc/BRIEF.md
# In-Order Pipeline Timing Skeleton with Multi-Slot Execute

This block models the timing of a single-issue, in-order core. It carries no data, only an instruction tag and an execution latency for each operation. An operation passes through three registered stages: fetch, decode and issue. It then enters a pool of independent execute slots. Each slot counts the operation's latency down and announces the completion together with the tag.

Issue holds its operation while the operands are reported as not yet read, or while every execute slot is occupied. The hold spreads backward through decode and fetch, and the fetch port stops accepting new work once the pipe is full. A long operation such as a divide occupies only its own slot, so shorter operations behind it still enter execute and can finish first. The block is meant to be driven from an instruction trace, with its completion outputs logged in order to estimate cycle counts.

Top module: `inorder_timing_core`

## Requirements
- R1: After reset, fetch_ready is 1, and slot_busy, slot_remain and done_mask are all 0.
- R2: An operation accepted on clock edge A (fetch_valid and fetch_ready both high) spends one cycle in each of fetch, decode and issue. With no hold, it enters an execute slot on edge A+3 and never earlier. After that edge the slot shows busy, and slot_remain shows the effective latency.
- R3: A slot loaded on edge X with effective latency L decrements slot_remain by one on each edge. It drives its done_mask bit high for exactly the one cycle that follows edge X+L, with the tag on its done_tags field (slot s occupies bits s*TAG_W upward), and it is idle again after that edge.
- R4: A fetch_lat value of 0 selects the default latency of 2 cycles. Any other value is used as given.
- R5: A slot holding a long operation does not block later operations. They enter other free slots and may complete first.
- R6: An issuing operation takes the lowest-numbered slot that is idle before the edge. A slot that finishes on an edge is free for loading from the next edge onward.
- R7: When every slot is busy, issue holds its operation. Decode and fetch then hold too, and fetch_ready drops once the fetch stage is full and cannot move.
- R8: While opnd_ready is 0, an operation in issue stays there and keeps its tag and latency. No slot is loaded until opnd_ready returns to 1.
- R9: Completions from several slots on the same cycle appear together as several set bits of done_mask.
- R10: A cycle with fetch_valid low travels down the pipe as an empty bubble and loads no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | An operation is offered to fetch |
| fetch_tag | input | TAG_W | Tag of the offered operation |
| fetch_lat | input | LAT_W | Execute latency; 0 selects the default of 2 |
| fetch_ready | output | 1 | Fetch accepts the offered operation on this edge |
| opnd_ready | input | 1 | Operands of the operation in issue have been read |
| slot_busy | output | SLOTS | One bit per execute slot, set while occupied |
| slot_remain | output | SLOTS*LAT_W | Remaining-cycle countdown of each slot |
| done_mask | output | SLOTS | Slots completing this cycle |
| done_tags | output | SLOTS*TAG_W | Tag of each slot's last completion |

## Verification
Each operation's completion is due on a fixed cycle, counted from its acceptance edge A: three hand-off edges, a load edge and L countdown edges put it at A+3+L when nothing holds. For held operations, the bench adds the cycles the operation waits in issue for a free slot or for opnd_ready. The driver records the acceptance cycle and queues the tag, the due cycle and the expected slot. The monitor samples on the falling edge and matches every set done_mask bit against the queue. A completion that comes late, early, in the wrong slot or without being expected fails its check. Slot countdowns, the hold of fetch_ready and the empty pool during held or idle cycles are sampled on their exact cycles.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

    localparam int TAG_W       = 8;
    localparam int LAT_W       = 8;
    localparam int DEFAULT_LAT = 2;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [LAT_W-1:0] lat;
    } ioc_op_t;

    // Latency field 0 selects the default execute latency.
    function automatic logic [LAT_W-1:0] eff_lat(input logic [LAT_W-1:0] raw);
        return (raw == '0) ? LAT_W'(DEFAULT_LAT) : raw;
    endfunction

endpackage

// File: rtl/ioc_stage.sv
module ioc_stage
    import ioc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ioc_op_t in_op,
    input  logic    down_take,
    output logic    up_ready,
    output ioc_op_t q
);

    assign up_ready = !q.valid || down_take;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (up_ready) begin
            q <= in_op;
        end
    end

    // Held stage keeps its operation unchanged (R8, R7)
    p_hold_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (q.valid && !down_take) |=> (q.valid && $stable(q)));

endmodule

// File: rtl/ioc_slot_pick.sv
module ioc_slot_pick #(
    parameter int SLOTS = 4
) (
    input  logic [SLOTS-1:0] busy,
    output logic [SLOTS-1:0] grant,
    output logic             any_free
);

    always_comb begin
        grant = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

    assign any_free = !(&busy);

endmodule

// File: rtl/ioc_exec_slot.sv
module ioc_exec_slot
    import ioc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TAG_W-1:0] load_tag,
    input  logic [LAT_W-1:0] load_lat,
    output logic             busy,
    output logic [LAT_W-1:0] remain,
    output logic             done,
    output logic [TAG_W-1:0] done_tag
);

    logic [TAG_W-1:0] held_tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            remain   <= '0;
            done     <= 1'b0;
            done_tag <= '0;
            held_tag <= '0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (remain == LAT_W'(1)) begin
                    busy     <= 1'b0;
                    remain   <= '0;
                    done     <= 1'b1;
                    done_tag <= held_tag;
                end else begin
                    remain <= remain - 1'b1;
                end
            end else if (load) begin
                busy     <= 1'b1;
                remain   <= eff_lat(load_lat);
                held_tag <= load_tag;
            end
        end
    end

    // Last count leads to a single completion pulse and an idle slot (R3)
    p_finish_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && remain == LAT_W'(1)) |=> (done && !busy));

    // Countdown steps by one per cycle (R3)
    p_countdown_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && remain > LAT_W'(1)) |=> (busy && remain == $past(remain) - 1'b1));

    // Loads arrive only for idle slots (R6)
    p_load_idle_r6: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy);

    // Completion pulse lasts one cycle (R3)
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/inorder_timing_core.sv
module inorder_timing_core
    import ioc_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   fetch_valid,
    input  logic [TAG_W-1:0]       fetch_tag,
    input  logic [LAT_W-1:0]       fetch_lat,
    output logic                   fetch_ready,
    input  logic                   opnd_ready,
    output logic [SLOTS-1:0]       slot_busy,
    output logic [SLOTS*LAT_W-1:0] slot_remain,
    output logic [SLOTS-1:0]       done_mask,
    output logic [SLOTS*TAG_W-1:0] done_tags
);

    localparam int NSTAGE = 3;
    localparam int ISS    = NSTAGE - 1;

    ioc_op_t          port_op;
    ioc_op_t          st_in   [NSTAGE];
    ioc_op_t          st_q    [NSTAGE];
    logic             st_rdy  [NSTAGE];
    logic             st_take [NSTAGE];

    logic [SLOTS-1:0] grant;
    logic [SLOTS-1:0] load_vec;
    logic             any_free;
    logic             issue_fire;

    assign port_op.valid = fetch_valid;
    assign port_op.tag   = fetch_tag;
    assign port_op.lat   = fetch_lat;

    // Fetch, decode and issue registers; the hand-offs are chained from issue back to fetch
    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign st_in[g] = port_op;
        end else begin : g_body
            assign st_in[g] = st_q[g-1];
        end
        if (g == ISS) begin : g_tail
            assign st_take[g] = issue_fire;
        end else begin : g_mid
            assign st_take[g] = st_rdy[g+1];
        end
        ioc_stage u_stage (
            .clk      (clk),
            .rst      (rst),
            .in_op    (st_in[g]),
            .down_take(st_take[g]),
            .up_ready (st_rdy[g]),
            .q        (st_q[g])
        );
    end

    assign fetch_ready = st_rdy[0];

    ioc_slot_pick #(.SLOTS(SLOTS)) u_pick (
        .busy    (slot_busy),
        .grant   (grant),
        .any_free(any_free)
    );

    assign issue_fire = st_q[ISS].valid && opnd_ready && any_free;
    assign load_vec   = issue_fire ? grant : '0;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        ioc_exec_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .load    (load_vec[s]),
            .load_tag(st_q[ISS].tag),
            .load_lat(st_q[ISS].lat),
            .busy    (slot_busy[s]),
            .remain  (slot_remain[s*LAT_W +: LAT_W]),
            .done    (done_mask[s]),
            .done_tag(done_tags[s*TAG_W +: TAG_W])
        );
    end

    // At most one slot loaded per edge (R6)
    p_one_load_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_vec));

    // A full pool never accepts a load (R7)
    p_full_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        (&slot_busy) |-> (load_vec == '0));

    // Refused fetch means the fetch register is occupied (R7)
    p_ready_drop_r7: assert property (@(posedge clk) disable iff (rst)
        !fetch_ready |-> st_q[0].valid);

    // Operands not read: nothing enters execute (R8)
    p_opnd_wait_r8: assert property (@(posedge clk) disable iff (rst)
        !opnd_ready |=> ($countones(slot_busy) <= $countones($past(slot_busy))));

    // A bubble in issue loads no slot (R10)
    p_bubble_r10: assert property (@(posedge clk) disable iff (rst)
        !st_q[ISS].valid |-> (load_vec == '0));

endmodule

// File: tb/inorder_timing_core_tb.sv
module inorder_timing_core_tb;
    import ioc_pkg::*;

    localparam int SLOTS = 4;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   fetch_valid = 1'b0;
    logic [TAG_W-1:0]       fetch_tag = '0;
    logic [LAT_W-1:0]       fetch_lat = '0;
    logic                   fetch_ready;
    logic                   opnd_ready = 1'b1;
    logic [SLOTS-1:0]       slot_busy;
    logic [SLOTS*LAT_W-1:0] slot_remain;
    logic [SLOTS-1:0]       done_mask;
    logic [SLOTS*TAG_W-1:0] done_tags;

    inorder_timing_core #(.SLOTS(SLOTS)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .fetch_valid(fetch_valid),
        .fetch_tag  (fetch_tag),
        .fetch_lat  (fetch_lat),
        .fetch_ready(fetch_ready),
        .opnd_ready (opnd_ready),
        .slot_busy  (slot_busy),
        .slot_remain(slot_remain),
        .done_mask  (done_mask),
        .done_tags  (done_tags)
    );

    always #2 clk = ~clk;   // 250 MHz

    int cyc = 0;
    always @(posedge clk) if (!rst) cyc <= cyc + 1;

    int n_total = 0;
    int n_fail  = 0;
    bit ended   = 0;

    typedef struct { int tag; int due; int slot; string req; } exp_t;
    exp_t exp_q[$];

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
        end
    endtask

    task automatic expect_done(input int tag, input int due, input int slot, input string req);
        exp_t e;
        e.tag = tag; e.due = due; e.slot = slot; e.req = req;
        exp_q.push_back(e);
    endtask

    // Offer one operation; returns the acceptance edge number and the cycles held off
    task automatic push_op(input int tag, input int lat, output int acc, output int waited);
        waited = 0;
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_tag   = TAG_W'(tag);
        fetch_lat   = LAT_W'(lat);
        #1;
        while (!fetch_ready) begin
            waited++;
            @(negedge clk);
            #1;
        end
        acc = cyc + 1;
        @(posedge clk);
        #1;
        fetch_valid = 1'b0;
    endtask

    task automatic at_cycle(input int n);
        do @(negedge clk); while (cyc < n);
        #1;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: match completions against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && !ended) begin
                for (int s = 0; s < SLOTS; s++) begin
                    if (done_mask[s]) begin
                        int t;
                        int hit;
                        t   = int'(done_tags[s*TAG_W +: TAG_W]);
                        hit = -1;
                        for (int k = 0; k < exp_q.size(); k++)
                            if (exp_q[k].tag == t && hit < 0) hit = k;
                        if (hit < 0) begin
                            check(1'b0, "R3 unexpected completion tag", t, -1);
                        end else begin
                            check(exp_q[hit].due == cyc, exp_q[hit].req, cyc, exp_q[hit].due);
                            if (exp_q[hit].slot >= 0)
                                check(exp_q[hit].slot == s, {exp_q[hit].req, " slot"}, s, exp_q[hit].slot);
                            exp_q.delete(hit);
                        end
                    end
                end
                for (int k = exp_q.size() - 1; k >= 0; k--) begin
                    if (exp_q[k].due < cyc) begin
                        check(1'b0, {exp_q[k].req, " missing completion"}, exp_q[k].tag, exp_q[k].due);
                        exp_q.delete(k);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        int a;
        int w;
        int base;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check(fetch_ready == 1'b1, "R1 fetch_ready", int'(fetch_ready), 1);
        check(slot_busy == '0, "R1 slot_busy", int'(slot_busy), 0);
        check(slot_remain == '0, "R1 slot_remain", int'(slot_remain), 0);
        check(done_mask == '0, "R1 done_mask", int'(done_mask), 0);

        // R2/R3/R4: single op with default latency (field 0 -> 2)
        push_op(1, 0, a, w);
        expect_done(1, a + 5, 0, "R4 default latency done");
        at_cycle(a + 2);
        check(slot_busy == '0, "R2 not in execute before A+3", int'(slot_busy), 0);
        at_cycle(a + 3);
        check(slot_busy[0] == 1'b1, "R2 enters execute at A+3", int'(slot_busy[0]), 1);
        check(int'(slot_remain[0 +: LAT_W]) == 2, "R4 remain shows 2", int'(slot_remain[0 +: LAT_W]), 2);
        at_cycle(a + 4);
        check(int'(slot_remain[0 +: LAT_W]) == 1, "R3 countdown", int'(slot_remain[0 +: LAT_W]), 1);
        drain();
        // R10: idle bubbles load nothing
        check(slot_busy == '0, "R10 bubbles leave pool idle", int'(slot_busy), 0);

        // R5/R9: divide followed by short ops
        push_op(2, 20, base, w);
        expect_done(2, base + 23, 0, "R5 divide done");
        push_op(3, 2, a, w);
        check(a == base + 1, "R5 back-to-back accept", a, base + 1);
        expect_done(3, base + 6, 1, "R5 short op passes divide");
        push_op(4, 2, a, w);
        expect_done(4, base + 7, 2, "R9 joint completion");
        push_op(5, 1, a, w);
        expect_done(5, base + 7, 3, "R9 joint completion");
        at_cycle(base + 7);
        check(done_mask == 4'b1100, "R9 two bits in done_mask", int'(done_mask), 12);
        drain();

        // R6/R7: fill the pool, then stall
        push_op(10, 30, base, w);
        expect_done(10, base + 33, 0, "R6 fill slot0");
        push_op(11, 30, a, w);
        expect_done(11, base + 34, 1, "R6 fill slot1");
        push_op(12, 30, a, w);
        expect_done(12, base + 35, 2, "R6 fill slot2");
        push_op(13, 30, a, w);
        expect_done(13, base + 36, 3, "R6 fill slot3");
        push_op(14, 2, a, w);
        expect_done(14, base + 36, 0, "R7 waits for free slot");
        push_op(15, 1, a, w);
        expect_done(15, base + 36, 1, "R6 reuse freed slot1");
        push_op(16, 1, a, w);
        expect_done(16, base + 37, 2, "R6 reuse freed slot2");
        push_op(17, 1, a, w);
        check(a == base + 34, "R7 fetch held until pool frees", a, base + 34);
        check(w > 0, "R7 fetch_ready dropped", w, 1);
        expect_done(17, base + 38, 0, "R6 lowest free slot");
        drain();

        // R8: operands not read hold the op in issue
        @(negedge clk);
        opnd_ready = 1'b0;
        push_op(20, 2, a, w);
        expect_done(20, a + 10, 0, "R8 release after opnd_ready");
        at_cycle(a + 4);
        check(slot_busy == '0, "R8 held in issue", int'(slot_busy), 0);
        at_cycle(a + 7);
        check(slot_busy == '0, "R8 still held", int'(slot_busy), 0);
        opnd_ready = 1'b1;
        at_cycle(a + 8);
        check(slot_busy[0] == 1'b1 && int'(slot_remain[0 +: LAT_W]) == 2,
              "R8 tag/latency kept", int'(slot_remain[0 +: LAT_W]), 2);
        drain();

        ended = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule